// File: doc/BRIEF.md
# SDRAM Single-Read Command Sequencer

This block sits on the controller side of an SDRAM interface. It performs one isolated read with a precharge that it issues itself. A request names a bank, a row and a column, and a flag selects whether the closing precharge covers every bank or only the addressed one. The block opens the row with ACTIVE and waits out the row-to-column delay. It then issues READ with the auto-precharge bit cleared and samples the single returning word after the CAS latency. It closes the row with an explicit PRECHARGE and keeps itself busy until the next ACTIVE is legal.

The minimum row timings are given as picosecond parameters together with the clock period. Each one becomes a clock-cycle count by ceiling division. Each count is loaded into its own down-counter at the command that starts that interval. The clock enable is held high and the byte masks are held low throughout. The requester may present a new request as soon as `busy` is low, and accepted requests then issue back to back at the legal spacing.

Top module: `sdr_single_read`

## Requirements
- R1: While `rstN` is low, the command pins show NOP, `sdBa`, `sdAddr` and `rdData` are zero, and `busy` and `rdValid` are low.
- R2: A request is accepted at a rising edge where `reqValid` is high and `busy` is low. In the following cycle the pins carry ACTIVE with `reqRow` on `sdAddr` and `reqBank` on `sdBa`, and `busy` is high.
- R3: READ appears rcdCyc = ceil(TRCD_PS/CLK_PS) cycles after ACTIVE (2 by default). The latched column sits on the low column bits of `sdAddr`, A10 (bit 10) is low, all other address bits are zero, and the latched bank is on `sdBa`.
- R4: `dqIn` is sampled at the rising edge that lies CAS_LAT edges after the edge on which the memory takes READ. `rdData` takes that word and `rdValid` is high for exactly the one following cycle (5 cycles after ACTIVE by default).
- R5: PRECHARGE appears max(rasCyc, rcdCyc+CAS_LAT) cycles after ACTIVE (5 by default). Bit 10 of `sdAddr` equals the latched `reqPreAll`, the other address bits are zero, and the latched bank is on `sdBa`.
- R6: `busy` stays high until max(rcCyc, preCycle+rpCyc) cycles after ACTIVE (7 by default). With `reqValid` held high, consecutive ACTIVE commands are exactly that many cycles apart.
- R7: Commands are encoded on {csN, rasN, casN, weN} as ACTIVE 0011, READ 0101, PRECHARGE 0010 and NOP 0111. Every cycle that carries none of the first three shows NOP with `sdAddr` and `sdBa` zero.
- R8: Requests presented while `busy` is high are ignored. They change neither the command sequence nor the bank, row, column or precharge scope of the read in progress.
- R9: `sdCke` is always high and every bit of `sdDqm` is always low.
- R10: `rdData` holds the last captured word until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqBank | input | BANK_W | Bank to read |
| reqRow | input | ROW_W | Row to open |
| reqCol | input | COL_W | Column to read |
| reqPreAll | input | 1 | 1: close all banks, 0: close only the addressed bank |
| busy | output | 1 | High from acceptance until the next ACTIVE is legal |
| sdCke | output | 1 | Clock enable to the memory |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | BANK_W | Bank address |
| sdAddr | output | ROW_W | Row/column address, bit 10 is the precharge control |
| sdDqm | output | DATA_W/8 | Byte masks |
| dqIn | input | DATA_W | Data returning from the memory |
| rdData | output | DATA_W | Captured read word |
| rdValid | output | 1 | One-cycle strobe when `rdData` is updated |

## Verification
With the default timing, the data capture and the closing PRECHARGE land in the same cycle. The row-active limit and the read-data wait both expire at the fifth edge after ACTIVE, so `rdValid` rises in the cycle whose command pins carry PRECHARGE. Requests held high back to back reach this overlap on every read, and the memory model in the bench drives the correct word only in the single legal sampling window. If the precharge is issued a cycle early or the capture is skewed, the cycle-by-cycle reference reports a miscompare. A second collision arises when the busy release and a waiting request coincide. At that edge the new ACTIVE must follow without a gap, and the bench judges this by comparing the command pins in every cycle.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // command encoding on {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdrCmd_e;

  // control -> datapath strobes, at most one per cycle
  typedef struct packed {
    logic act;
    logic rd;
    logic pre;
  } seqStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
  import sdr_rd_pkg::*;
#(
  parameter int CLK_PS  = 10000,
  parameter int TRCD_PS = 20000,
  parameter int TRAS_PS = 44000,
  parameter int TRP_PS  = 20000,
  parameter int TRC_PS  = 66000,
  parameter int CAS_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output seqStrobe_t strb,
  output logic       busy
);

  localparam int RCD_CYC = ceilDiv(TRCD_PS, CLK_PS);
  localparam int RAS_CYC = ceilDiv(TRAS_PS, CLK_PS);
  localparam int RP_CYC  = ceilDiv(TRP_PS, CLK_PS);
  localparam int RC_CYC  = ceilDiv(TRC_PS, CLK_PS);
  localparam int PRE_T   = maxOf(RAS_CYC, RCD_CYC + CAS_LAT);
  localparam int NEXT_T  = maxOf(RC_CYC, PRE_T + RP_CYC);
  localparam int TMR_MAX = maxOf(maxOf(RCD_CYC, RAS_CYC),
                                 maxOf(maxOf(RP_CYC, RC_CYC), CAS_LAT));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int NT      = 5;
  localparam int T_RCD   = 0;
  localparam int T_RAS   = 1;
  localparam int T_RC    = 2;
  localparam int T_CAS   = 3;
  localparam int T_RP    = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_RDWAIT, ST_CLOSE} seqState_e;

  seqState_e        state;
  logic [TMR_W-1:0] tmr     [NT];
  logic [TMR_W-1:0] tmrInit [NT];
  logic [NT-1:0]    tmrLoad;
  logic [NT-1:0]    tmrZero;
  logic             ready;

  assign tmrInit[T_RCD] = TMR_W'(RCD_CYC - 1);
  assign tmrInit[T_RAS] = TMR_W'(RAS_CYC - 1);
  assign tmrInit[T_RC]  = TMR_W'(RC_CYC - 1);
  assign tmrInit[T_CAS] = TMR_W'(CAS_LAT - 1);
  assign tmrInit[T_RP]  = TMR_W'(RP_CYC - 1);

  // each interval counter starts with the command that opens it
  assign tmrLoad = {strb.pre, strb.rd, strb.act, strb.act, strb.act};

  for (genvar i = 0; i < NT; i++) begin : gTmr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              tmr[i] <= '0;
      else if (tmrLoad[i])    tmr[i] <= tmrInit[i];
      else if (tmr[i] != '0)  tmr[i] <= tmr[i] - TMR_W'(1);
    end
    assign tmrZero[i] = (tmr[i] == '0);
  end

  assign ready    = (state == ST_IDLE) ||
                    ((state == ST_CLOSE) && tmrZero[T_RP] && tmrZero[T_RC]);
  assign busy     = !ready;
  assign strb.act = ready && reqValid;
  assign strb.rd  = (state == ST_OPEN) && tmrZero[T_RCD];
  assign strb.pre = (state == ST_RDWAIT) && tmrZero[T_RAS] && tmrZero[T_CAS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (strb.act) begin
      state <= ST_OPEN;
    end else begin
      case (state)
        ST_OPEN:   if (strb.rd)  state <= ST_RDWAIT;
        ST_RDWAIT: if (strb.pre) state <= ST_CLOSE;
        ST_CLOSE:  if (ready)    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // checker counter: edges since the last ACTIVE strobe, saturating
  localparam int SINCE_W = $clog2(NEXT_T + 1) + 1;
  logic [SINCE_W-1:0] sinceAct;
  logic               actSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAct <= '0;
      actSeen  <= 1'b0;
    end else begin
      if (strb.act)             sinceAct <= SINCE_W'(1);
      else if (sinceAct != '1)  sinceAct <= sinceAct + SINCE_W'(1);
      if (strb.act)             actSeen  <= 1'b1;
    end
  end

  assert_read_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.rd |-> (sinceAct == SINCE_W'(RCD_CYC)));

  assert_pre_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pre |-> (sinceAct >= SINCE_W'(RAS_CYC)) &&
                 (sinceAct >= SINCE_W'(RCD_CYC + CAS_LAT)));

  assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.act && actSeen) |-> (sinceAct >= SINCE_W'(NEXT_T)));

  assert_busy_on_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |=> busy);

endmodule

// File: rtl/sdr_rd_datapath.sv
module sdr_rd_datapath
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int AP_BIT  = 10,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqPreAll,
  input  logic [DATA_W-1:0] dqIn,
  output logic [3:0]        cmdBits,
  output logic [BANK_W-1:0] baOut,
  output logic [ROW_W-1:0]  addrOut,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic              preAllQ;
  sdrCmd_e           cmdQ;
  logic [ROW_W-1:0]  colAddr;
  logic [ROW_W-1:0]  preAddr;
  logic              rdPipe [CAS_LAT + 1];

  // request fields are taken once, with ACTIVE
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ   <= '0;
      colQ    <= '0;
      preAllQ <= 1'b0;
    end else if (strb.act) begin
      bankQ   <= reqBank;
      colQ    <= reqCol;
      preAllQ <= reqPreAll;
    end
  end

  // column placement skips the precharge-control bit when it is wide
  if (COL_W <= AP_BIT) begin : gColNarrow
    always_comb begin
      colAddr = '0;
      colAddr[COL_W-1:0] = colQ;
    end
  end else begin : gColWide
    always_comb begin
      colAddr = '0;
      colAddr[AP_BIT-1:0] = colQ[AP_BIT-1:0];
      colAddr[COL_W:AP_BIT+1] = colQ[COL_W-1:AP_BIT];
    end
  end

  always_comb begin
    preAddr = '0;
    preAddr[AP_BIT] = preAllQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      baOut   <= '0;
      addrOut <= '0;
    end else if (strb.act) begin
      cmdQ    <= CMD_ACT;
      baOut   <= reqBank;
      addrOut <= reqRow;
    end else if (strb.rd) begin
      cmdQ    <= CMD_RD;
      baOut   <= bankQ;
      addrOut <= colAddr;
    end else if (strb.pre) begin
      cmdQ    <= CMD_PRE;
      baOut   <= bankQ;
      addrOut <= preAddr;
    end else begin
      cmdQ    <= CMD_NOP;
      baOut   <= '0;
      addrOut <= '0;
    end
  end

  assign cmdBits = cmdQ;

  // read latency pipeline: stage k is set k edges after READ is registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPipe[0] <= 1'b0;
    else       rdPipe[0] <= strb.rd;
  end

  for (genvar s = 1; s <= CAS_LAT; s++) begin : gLat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rdPipe[s] <= 1'b0;
      else       rdPipe[s] <= rdPipe[s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdPipe[CAS_LAT];
      if (rdPipe[CAS_LAT]) rdData <= dqIn;
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

  assert_read_no_autopre_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.rd |=> (cmdBits == CMD_RD) && !addrOut[AP_BIT]);

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdPipe[CAS_LAT] |=> $stable(rdData));

endmodule

// File: rtl/sdr_single_read.sv
module sdr_single_read
  import sdr_rd_pkg::*;
#(
  parameter int CLK_PS  = 10000,
  parameter int TRCD_PS = 20000,
  parameter int TRAS_PS = 44000,
  parameter int TRP_PS  = 20000,
  parameter int TRC_PS  = 66000,
  parameter int CAS_LAT = 2,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int AP_BIT  = 10,
  localparam int DQM_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqPreAll,
  output logic              busy,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [DQM_W-1:0]  sdDqm,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  seqStrobe_t strb;
  logic [3:0] cmdBits;

  sdr_rd_ctrl #(
    .CLK_PS (CLK_PS),
    .TRCD_PS(TRCD_PS),
    .TRAS_PS(TRAS_PS),
    .TRP_PS (TRP_PS),
    .TRC_PS (TRC_PS),
    .CAS_LAT(CAS_LAT)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strb    (strb),
    .busy    (busy)
  );

  sdr_rd_datapath #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .AP_BIT (AP_BIT),
    .CAS_LAT(CAS_LAT)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqBank  (reqBank),
    .reqRow   (reqRow),
    .reqCol   (reqCol),
    .reqPreAll(reqPreAll),
    .dqIn     (dqIn),
    .cmdBits  (cmdBits),
    .baOut    (sdBa),
    .addrOut  (sdAddr),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdBits;
  assign sdCke = 1'b1;
  assign sdDqm = '0;

endmodule

// File: tb/test_sdr_single_read.sv
`timescale 1ns/1ps
module test_sdr_single_read;

  function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
  function automatic int imax(int a, int b); return a > b ? a : b; endfunction

  localparam int CL    = 2;
  localparam int RCD   = cdiv(20000, 10000);
  localparam int TPRE  = imax(cdiv(44000, 10000), RCD + CL);
  localparam int TNEXT = imax(cdiv(66000, 10000), TPRE + cdiv(20000, 10000));
  localparam int TDATA = RCD + CL + 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, reqValid, reqPreAll;
  logic [1:0]  reqBank;
  logic [11:0] reqRow;
  logic [8:0]  reqCol;
  logic        busy, sdCke, sdCsN, sdRasN, sdCasN, sdWeN, rdValid;
  logic [1:0]  sdBa, sdDqm;
  logic [11:0] sdAddr;
  logic [15:0] dqIn, rdData;

  sdr_single_read i_sdr_single_read (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqPreAll(reqPreAll), .busy(busy),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
    .sdWeN(sdWeN), .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm),
    .dqIn(dqIn), .rdData(rdData), .rdValid(rdValid)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit          mActive = 0, busyExp = 0, ignoredReq = 0;
  int          p = 0;
  logic [1:0]  mBank;
  logic [11:0] mRow;
  logic [8:0]  mCol;
  logic        mPreAll;
  logic [15:0] mData = '0;

  // memory emulation state
  logic [11:0] openRow [4];
  int          rdCnt = 0;
  bit          armed = 0;
  logic [15:0] pendWord;

  function automatic logic [15:0] word(logic [1:0] b, logic [11:0] r, logic [8:0] c);
    return (16'(b) * 16'h4111) ^ (16'(r) * 16'd5) ^ (16'(c) << 5) ^ 16'h5A5A;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  task automatic step();
    logic [3:0]  cmdExp;
    logic [11:0] addrExp;
    logic [1:0]  baExp;
    logic        vldExp;
    string       sfx, cmdTag;
    cyc++;
    // advance the model across the rising edge just passed
    if (!rstN) begin
      mActive = 0; p = 0; mData = '0; ignoredReq = 0;
    end else begin
      if (mActive && p < 1000) p++;
      if (!busyExp && reqValid) begin
        mActive = 1; p = 0; ignoredReq = 0;
        mBank = reqBank; mRow = reqRow; mCol = reqCol; mPreAll = reqPreAll;
      end else if (busyExp && reqValid) begin
        ignoredReq = 1;
      end
    end
    busyExp = mActive && (p < TNEXT - 1);
    vldExp  = mActive && (p == TDATA);
    if (vldExp) mData = word(mBank, mRow, mCol);
    cmdExp = 4'b0111; addrExp = '0; baExp = '0; cmdTag = "R7";
    if (mActive && p == 0)    begin cmdExp = 4'b0011; addrExp = mRow; baExp = mBank; cmdTag = "R2"; end
    if (mActive && p == RCD)  begin cmdExp = 4'b0101; addrExp = {3'b000, mCol}; baExp = mBank; cmdTag = "R3"; end
    if (mActive && p == TPRE) begin cmdExp = 4'b0010; addrExp = {1'b0, mPreAll, 10'b0}; baExp = mBank; cmdTag = "R5"; end
    sfx = ignoredReq ? "/R8" : "";
    if (!rstN) begin
      chk("R1 cmd", 32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'(4'b0111));
      chk("R1 addr/ba", 32'({sdBa, sdAddr}), 32'd0);
      chk("R1 busy/valid", 32'({busy, rdValid}), 32'd0);
      chk("R1 rdData", 32'(rdData), 32'd0);
    end else begin
      chk({cmdTag, sfx, " cmd"}, 32'({sdCsN, sdRasN, sdCasN, sdWeN}), 32'(cmdExp));
      chk({cmdTag, sfx, " addr"}, 32'(sdAddr), 32'(addrExp));
      chk({cmdTag, sfx, " bank"}, 32'(sdBa), 32'(baExp));
      chk({"R6", sfx, " busy"}, 32'(busy), 32'(busyExp));
      chk({"R4", sfx, " rdValid"}, 32'(rdValid), 32'(vldExp));
      chk({"R4/R10", sfx, " rdData"}, 32'(rdData), 32'(mData));
    end
    chk("R9 cke/dqm", 32'({sdCke, sdDqm}), 32'(3'b100));
    // memory emulation: word valid only in the CL-th cycle after READ
    if (rdCnt > 0) rdCnt--;
    if (armed && rdCnt == 0) begin dqIn = pendWord; armed = 0; end
    else dqIn = 16'(cyc * 16'h9E37) ^ 16'h0F0F;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0011) openRow[sdBa] = sdAddr;
    if ({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0101) begin
      armed = 1; rdCnt = CL;
      pendWord = word(sdBa, openRow[sdBa], sdAddr[8:0]);
    end
  endtask

  task automatic drive(bit v, logic [1:0] b, logic [11:0] r, logic [8:0] c, bit pa);
    reqValid = v; reqBank = b; reqRow = r; reqCol = c; reqPreAll = pa;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); step(); end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) openRow[i] = '0;
    rstN = 1'b1; dqIn = '0;
    drive(0, 0, 0, 0, 0);
    #1 rstN = 1'b0;
    cycles(3);                           // R1 reset state
    rstN = 1'b1;
    // R2 R3 R4 R5: single read, one-bank precharge
    cycles(1); drive(1, 2'd1, 12'h123, 9'h045, 0);
    cycles(1); drive(0, 0, 0, 0, 0);
    cycles(12);
    // R5: all-bank precharge with extreme address values
    drive(1, 2'd3, 12'hFFF, 9'h1FF, 1);
    cycles(1); drive(0, 0, 0, 0, 0);
    cycles(10);
    // R6 R8: requests held back to back with fields changing every cycle
    for (int i = 0; i < 40; i++) begin
      drive(1, 2'($urandom), 12'($urandom), 9'($urandom), 1'($urandom));
      cycles(1);
    end
    drive(0, 0, 0, 0, 0);
    cycles(10);
    // sparse random requests
    for (int i = 0; i < 300; i++) begin
      drive(($urandom % 3) == 0, 2'($urandom), 12'($urandom), 9'($urandom), 1'($urandom));
      cycles(1);
    end
    // R1: reset in the middle of a read
    drive(1, 2'd2, 12'h0A5, 9'h100, 0);
    cycles(3);
    rstN = 1'b0; drive(0, 0, 0, 0, 0);
    cycles(2);
    rstN = 1'b1;
    drive(1, 2'd0, 12'h000, 9'h000, 1);
    cycles(1); drive(0, 0, 0, 0, 0);
    cycles(15);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R6 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule